// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Router

This block gathers level-sensitive interrupt requests from four PCI interrupt pins and up to seven on-chip functions and steers each onto one of sixteen ISA IRQ lines. A source reports a level change as a one-cycle event strobe. The strobe carries the source identifier, the new level and, for on-chip functions, the IRQ number that the function has programmed. PCI pins do not carry an IRQ number. Their IRQ comes from routing nibbles in three configuration bytes that the block receives as inputs.

Internally the router keeps one global mask of the sources that are currently asserting. It also keeps one mask per IRQ line, recording which sources drive that line. Every IRQ output is the OR of its own mask. When a valid event updates a line's mask, that mask is ANDed with the global mask. Any bit left behind by an earlier mapping is removed at that point, so a source can be moved to another IRQ without leaving its old line stuck high. Events that name a disabled or illegal IRQ still update the global mask but leave every line mask alone.

Top module: `irq_router`

## Requirements
- R1: After reset every bit of `isa_irq` is low.
- R2: Source ids 8, 9, 10 and 11 are PCI pins 0 to 3. Each pin takes its IRQ from a configuration nibble and ignores `ev_irq`. Pin 0 uses `pirq_cfg_lo[7:4]`. Pin 1 uses `pirq_cfg_mid[3:0]`. Pin 2 uses `pirq_cfg_mid[7:4]`. Pin 3 uses `pirq_cfg_hi[7:4]`.
- R3: Source ids 1 to 7 are on-chip functions with that function number. They route to the IRQ given by `ev_irq`, and source id n owns bit n of every mask.
- R4: An IRQ line stays high while at least one source routed to it is asserting. It drops only when the last of those sources deasserts.
- R5: An event whose IRQ is 0 or 0xFF changes no line mask, but it still records the source's level in the global mask.
- R6: An event whose IRQ is 2 is rejected, and `isa_irq[2]` is never driven high.
- R7: Functions 2, 3 and 5 may use IRQs up to 14 only. Every other source may use IRQs up to 15.
- R8: An on-chip function event whose `ev_irq` is above 15 (other than 0xFF) changes no line mask.
- R9: On a valid event, the target line's mask is ANDed with the updated global mask. This clears bits of sources that have since deasserted through a disabled route.
- R10: If a PCI pin's route changes while the pin is asserted, its old line stays high until a later valid event on that line scrubs the bit left behind.
- R11: A cycle without a strobe, or a strobe with source id 0 or 12 to 15, leaves every output unchanged.
- R12: An accepted event changes `isa_irq` on the first rising clock edge after the strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_cfg_lo | input | 8 | Routing byte, bits 7:4 give the IRQ of PCI pin 0 |
| pirq_cfg_mid | input | 8 | Routing byte, bits 3:0 give pin 1 and bits 7:4 give pin 2 |
| pirq_cfg_hi | input | 8 | Routing byte, bits 7:4 give the IRQ of PCI pin 3 |
| ev_valid | input | 1 | One-cycle event strobe |
| ev_src | input | 4 | Source id: 1 to 7 are functions, 8 to 11 are PCI pins 0 to 3 |
| ev_level | input | 1 | New level of the source, 1 means asserting |
| ev_irq | input | 8 | Programmed IRQ of an on-chip function |
| isa_irq | output | 16 | ISA IRQ line levels, bit n is IRQ n |

## Verification
Each accepted event is due on `isa_irq` one rising edge after the strobe. The line masks are registers and the outputs are an OR of those registers with no further stage. The bench drives every event on a falling edge and removes the strobe on the next falling edge, where it also samples the outputs. One check for R12 samples just after driving the strobe, to show that the old value still holds before the edge. Rejected and ignored events are checked at that same falling edge against the unchanged vector. Stale bits are checked over several events in a row, and each event's result is read before the next event is driven.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ROUTER_IRQS = 16;
    localparam int SRC_BITS    = 16;
    localparam int SLOT_W      = $clog2(ROUTER_IRQS);
    localparam int SRC_IDX_W   = $clog2(SRC_BITS);

    typedef logic [SRC_BITS-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t                     active;
        src_vec_t [ROUTER_IRQS-1:0]   per_irq;
    } route_state_t;

    typedef struct packed {
        logic                 hit;
        logic                 route_ok;
        logic [SLOT_W-1:0]    slot;
        logic [SRC_IDX_W-1:0] bit_idx;
        logic                 level;
    } route_req_t;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_router_pkg::*;
#(
    parameter int              IRQ_W         = 8,
    parameter int              FULL_MAX      = 15,
    parameter int              REDUCED_MAX   = 14,
    parameter logic [7:0]      REDUCED_FNS   = 8'b0010_1100
) (
    input  logic                 ev_valid,
    input  logic [SRC_IDX_W-1:0] ev_src,
    input  logic                 ev_level,
    input  logic [IRQ_W-1:0]     ev_irq,
    input  logic [7:0]           pirq_cfg_lo,
    input  logic [7:0]           pirq_cfg_mid,
    input  logic [7:0]           pirq_cfg_hi,
    output route_req_t           req
);

    localparam logic [IRQ_W-1:0] FULL_L    = IRQ_W'(FULL_MAX);
    localparam logic [IRQ_W-1:0] REDUCED_L = IRQ_W'(REDUCED_MAX);
    localparam logic [IRQ_W-1:0] CASCADE_L = IRQ_W'(2);

    logic             is_pin;
    logic             is_fn;
    logic [3:0]       pin_nib;
    logic [IRQ_W-1:0] irq_eff;
    logic [IRQ_W-1:0] limit;
    logic             disabled;

    always_comb begin
        is_pin = (ev_src[3:2] == 2'b10);
        is_fn  = (ev_src[3] == 1'b0) && (ev_src != '0);

        case (ev_src[1:0])
            2'd0:    pin_nib = pirq_cfg_lo[7:4];
            2'd1:    pin_nib = pirq_cfg_mid[3:0];
            2'd2:    pin_nib = pirq_cfg_mid[7:4];
            default: pin_nib = pirq_cfg_hi[7:4];
        endcase

        irq_eff  = is_pin ? IRQ_W'(pin_nib) : ev_irq;
        limit    = (is_fn && REDUCED_FNS[ev_src[2:0]]) ? REDUCED_L : FULL_L;
        disabled = (irq_eff == '0) || (irq_eff == {IRQ_W{1'b1}});

        req.hit      = ev_valid && (is_pin || is_fn);
        req.route_ok = req.hit && !disabled && (irq_eff <= limit)
                       && (irq_eff != CASCADE_L);
        req.slot     = irq_eff[SLOT_W-1:0];
        req.bit_idx  = ev_src;
        req.level    = ev_level;
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_router_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  route_req_t             req,
    output logic [ROUTER_IRQS-1:0] irq_lvl
);

    route_state_t st_d, st_q;
    src_vec_t     sel;

    always_comb begin
        st_d = st_q;
        sel  = st_q.per_irq[req.slot];
        if (req.hit) begin
            st_d.active[req.bit_idx] = req.level;
        end
        if (req.route_ok) begin
            sel[req.bit_idx]       = req.level;
            st_d.per_irq[req.slot] = sel & st_d.active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < ROUTER_IRQS; g++) begin : g_line
        assign irq_lvl[g] = |st_q.per_irq[g];
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             pirq_cfg_lo,
    input  logic [7:0]             pirq_cfg_mid,
    input  logic [7:0]             pirq_cfg_hi,
    input  logic                   ev_valid,
    input  logic [SRC_IDX_W-1:0]   ev_src,
    input  logic                   ev_level,
    input  logic [IRQ_W-1:0]       ev_irq,
    output logic [ROUTER_IRQS-1:0] isa_irq
);

    route_req_t req;

    irq_route_decode #(
        .IRQ_W (IRQ_W)
    ) u_decode (
        .ev_valid     (ev_valid),
        .ev_src       (ev_src),
        .ev_level     (ev_level),
        .ev_irq       (ev_irq),
        .pirq_cfg_lo  (pirq_cfg_lo),
        .pirq_cfg_mid (pirq_cfg_mid),
        .pirq_cfg_hi  (pirq_cfg_hi),
        .req          (req)
    );

    irq_mask_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .irq_lvl (isa_irq)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_valid,
    input logic [3:0]  ev_src,
    input logic        ev_level,
    input logic [7:0]  ev_irq,
    input logic [15:0] isa_irq
);

    logic fn_src;
    assign fn_src = (ev_src != 4'd0) && (ev_src < 4'd8);

    // R6
    cascade_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_irq[2]);

    // R5
    line_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_irq[0]);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(isa_irq));

    // R11
    bad_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_src == 4'd0 || ev_src >= 4'd12)) |=> $stable(isa_irq));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && fn_src && (ev_irq == 8'h00 || ev_irq == 8'hFF))
        |=> $stable(isa_irq));

    // R8
    over_range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && fn_src && ev_irq > 8'd15) |=> $stable(isa_irq));

    // R3
    fn_assert_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && fn_src && ev_level && ev_irq >= 8'd3 && ev_irq <= 8'd14)
        |=> isa_irq[$past(ev_irq[3:0])]);

endmodule

bind irq_router irq_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_src   (ev_src),
    .ev_level (ev_level),
    .ev_irq   (ev_irq),
    .isa_irq  (isa_irq)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pirq_cfg_lo = '0;
    logic [7:0]  pirq_cfg_mid = '0;
    logic [7:0]  pirq_cfg_hi = '0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_src = '0;
    logic        ev_level = 1'b0;
    logic [7:0]  ev_irq = '0;
    logic [15:0] isa_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_router dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pirq_cfg_lo  (pirq_cfg_lo),
        .pirq_cfg_mid (pirq_cfg_mid),
        .pirq_cfg_hi  (pirq_cfg_hi),
        .ev_valid     (ev_valid),
        .ev_src       (ev_src),
        .ev_level     (ev_level),
        .ev_irq       (ev_irq),
        .isa_irq      (isa_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (isa_irq !== exp) begin
            errors++;
            $display("FAIL %s: isa_irq=%h expected %h", req, isa_irq, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        ev_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive on a falling edge; result due after the next rising edge
    task automatic send(input logic [3:0] src, input logic lvl, input logic [7:0] irq);
        ev_valid = 1'b1;
        ev_src   = src;
        ev_level = lvl;
        ev_irq   = irq;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", 16'h0000);
        ev_src = 4'd1; ev_level = 1'b1; ev_irq = 8'd5;
        repeat (2) @(negedge clk);
        check("R11 no strobe", 16'h0000);
    endtask

    task automatic t_timing();
        do_reset();
        ev_valid = 1'b1; ev_src = 4'd6; ev_level = 1'b1; ev_irq = 8'd9;
        #1;
        check("R12 before edge", 16'h0000);
        @(negedge clk);
        ev_valid = 1'b0;
        check("R12 after edge", 16'h0200);
    endtask

    task automatic t_pins();
        do_reset();
        pirq_cfg_lo = 8'h5A; pirq_cfg_mid = 8'hA7; pirq_cfg_hi = 8'hB3;
        send(4'd8, 1'b1, 8'h00);  check("R2 pin0", 16'h0020);
        send(4'd9, 1'b1, 8'h00);  check("R2 pin1", 16'h00A0);
        send(4'd10, 1'b1, 8'h00); check("R2 pin2", 16'h04A0);
        send(4'd11, 1'b1, 8'h00); check("R2 pin3", 16'h0CA0);
        send(4'd9, 1'b0, 8'h00);  check("R2 pin1 off", 16'h0C20);
        send(4'd8, 1'b0, 8'h00);
        send(4'd10, 1'b0, 8'h00);
        send(4'd11, 1'b0, 8'h00); check("R2 all off", 16'h0000);
    endtask

    task automatic t_share();
        do_reset();
        send(4'd1, 1'b1, 8'd9); check("R3 fn1 irq9", 16'h0200);
        send(4'd4, 1'b1, 8'd9); check("R4 two on irq9", 16'h0200);
        send(4'd1, 1'b0, 8'd9); check("R4 one left", 16'h0200);
        send(4'd4, 1'b0, 8'd9); check("R4 none left", 16'h0000);
        send(4'd7, 1'b1, 8'd3); check("R3 fn7 irq3", 16'h0008);
    endtask

    task automatic t_disabled();
        do_reset();
        send(4'd3, 1'b1, 8'h00); check("R5 irq0", 16'h0000);
        send(4'd3, 1'b1, 8'hFF); check("R5 irq ff", 16'h0000);
        send(4'd1, 1'b1, 8'd5);  check("R9 fn1 on irq5", 16'h0020);
        send(4'd1, 1'b0, 8'h00); check("R5 disabled deassert", 16'h0020);
        send(4'd4, 1'b0, 8'd5);  check("R9 scrubbed", 16'h0000);
    endtask

    task automatic t_cascade();
        do_reset();
        send(4'd1, 1'b1, 8'd2); check("R6 fn irq2", 16'h0000);
        pirq_cfg_lo = 8'h20;
        send(4'd8, 1'b1, 8'h00); check("R6 pin irq2", 16'h0000);
    endtask

    task automatic t_limit();
        do_reset();
        send(4'd2, 1'b1, 8'd15); check("R7 fn2 irq15", 16'h0000);
        send(4'd5, 1'b1, 8'd15); check("R7 fn5 irq15", 16'h0000);
        send(4'd6, 1'b1, 8'd15); check("R7 fn6 irq15", 16'h8000);
        send(4'd3, 1'b1, 8'd14); check("R7 fn3 irq14", 16'hC000);
        pirq_cfg_hi = 8'hF0;
        send(4'd11, 1'b1, 8'h00); check("R7 pin3 irq15", 16'hC000);
    endtask

    task automatic t_range();
        do_reset();
        send(4'd1, 1'b1, 8'd16);  check("R8 irq16", 16'h0000);
        send(4'd7, 1'b1, 8'h40);  check("R8 irq64", 16'h0000);
        send(4'd7, 1'b1, 8'd12);  check("R8 then valid", 16'h1000);
    endtask

    task automatic t_remap();
        do_reset();
        pirq_cfg_lo = 8'h30;
        send(4'd8, 1'b1, 8'h00); check("R10 pin0 irq3", 16'h0008);
        pirq_cfg_lo = 8'h60;
        send(4'd8, 1'b0, 8'h00); check("R10 stale irq3", 16'h0008);
        pirq_cfg_mid = 8'h03;
        send(4'd9, 1'b0, 8'h00); check("R10 irq3 scrubbed", 16'h0000);
    endtask

    task automatic t_badsrc();
        do_reset();
        send(4'd0, 1'b1, 8'd5);  check("R11 src0", 16'h0000);
        send(4'd12, 1'b1, 8'd5); check("R11 src12", 16'h0000);
        send(4'd15, 1'b1, 8'd5); check("R11 src15", 16'h0000);
        send(4'd1, 1'b1, 8'd5);  check("R11 then valid", 16'h0020);
        send(4'd13, 1'b0, 8'd5); check("R11 src13 hold", 16'h0020);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_timing();
        t_pins();
        t_share();
        t_disabled();
        t_cascade();
        t_limit();
        t_range();
        t_remap();
        t_badsrc();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

endmodule